// File: doc/BRIEF.md
# Multi-core external interrupt distributor

This block fans a vector of external interrupt lines out to several processor cores. Each core receives its own interrupt vector of the same width as the input. Line N can only ever appear on bit N of a core's vector. Software decides which cores see each line by writing a routing mask for that line. Delivery is further gated by an enable bit per line and an enable bit per core. A software-assert bit per line raises that line as though its external input were active.

External inputs are asynchronous. They pass through a two-flop synchroniser before any gating. The per-core outputs come from flops. Configuration goes through a write port that takes one word per cycle and a read port with a one-cycle latency. Every routing mask resets to zero, so the block delivers nothing until software programs it.

Top module: `irqd_distributor`

## Requirements
- R1: After reset, all routing masks, the line-enable word, the core-enable word and the software-assert word read as zero. Every core output is zero whatever the external inputs are, and it stays zero until a routing mask is written, even with both enable words set to all ones.
- R2: Bit N of core C's output equals (synchronised external line N OR software-assert bit N) AND bit C of the routing mask of line N AND line-enable bit N AND core-enable bit C. Core C's vector is the slice `core_irq[C*NUM_LINES +: NUM_LINES]`.
- R3: An active line N appears only at bit N of the cores selected by its mask. It never appears at any other bit position.
- R4: When line-enable bit N is clear, bit N is zero on every core.
- R5: When core-enable bit C is clear, every bit of core C's vector is zero.
- R6: When software-assert bit N is set, line N is delivered while its external input is low.
- R7: A change on an external input appears at the outputs on the third rising clock edge after it is applied: two synchroniser flops and then the output flop.
- R8: A register write that is sampled on clock edge k changes the outputs on edge k+1.
- R9: The register map uses byte addresses, and only word-aligned addresses are mapped:
  - 0x00 holds the line-enable word (bit N is line N).
  - 0x04 holds the core-enable word (bit C is core C).
  - 0x08 holds the software-assert word (bit N is line N).
  - 0x40 + 4·N holds the routing mask of line N (bit C is core C).
  `rd_data` returns the addressed register, zero-extended, on the cycle after `rd_en`. It reads zero on every other cycle and for unmapped addresses.
- R10: A write to an unmapped address changes no register and no output. Unmapped addresses include any address whose low two bits are not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | NUM_LINES | Asynchronous external interrupt lines, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Read data, valid the cycle after rd_en |
| core_irq | output | NUM_CORES*NUM_LINES | Per-core interrupt vectors, core C at bits C*NUM_LINES upward |

## Verification
The hardest case to reach is a set output bit, because it needs four independent conditions to be true together: an active source, a mask bit, a line enable and a core enable. Uniformly random configuration words would make that rare on most bits. The random phase therefore biases the enable words toward dense values and writes routing masks on many lines, while it also drives random external and software-assert patterns. Directed steps then isolate one condition at a time, and they time the synchroniser path and the register-write path edge by edge.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LINE_EN,
        SEL_CORE_EN,
        SEL_SWSET,
        SEL_ROUTE
    } reg_sel_e;

    localparam int unsigned OFS_LINE_EN    = 32'h00;
    localparam int unsigned OFS_CORE_EN    = 32'h04;
    localparam int unsigned OFS_SWSET      = 32'h08;
    localparam int unsigned OFS_ROUTE_BASE = 32'h40;

endpackage

// File: rtl/irqd_sync.sv
module irqd_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;

    // cycles since reset, saturating; lets the delay check start only once history exists
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               age_q <= 2'd0;
        else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
    end

    a_r7_sync_two: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (stab_q == $past(async_in, 2)));

endmodule

// File: rtl/irqd_regfile.sv
module irqd_regfile
    import irqd_pkg::*;
#(
    parameter int unsigned NC = 4,
    parameter int unsigned NL = 32,
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic                   rd_en,
    input  logic [AW-1:0]          rd_addr,
    output logic [DW-1:0]          rd_data,
    output logic [NL-1:0]          line_en,
    output logic [NC-1:0]          core_en,
    output logic [NL-1:0]          swset,
    output logic [NL-1:0][NC-1:0]  route
);

    localparam int unsigned IDX_W     = (NL > 1) ? $clog2(NL) : 1;
    localparam int unsigned ROUTE_END = OFS_ROUTE_BASE + 4 * NL;

    function automatic reg_sel_e dec_sel(input int unsigned a);
        reg_sel_e s;
        s = SEL_NONE;
        if ((a & 32'd3) == 32'd0) begin
            if (a == OFS_LINE_EN)                            s = SEL_LINE_EN;
            else if (a == OFS_CORE_EN)                       s = SEL_CORE_EN;
            else if (a == OFS_SWSET)                         s = SEL_SWSET;
            else if (a >= OFS_ROUTE_BASE && a < ROUTE_END)   s = SEL_ROUTE;
        end
        return s;
    endfunction

    function automatic logic [IDX_W-1:0] dec_idx(input int unsigned a);
        return IDX_W'((a - OFS_ROUTE_BASE) >> 2);
    endfunction

    reg_sel_e          wsel, rsel;
    logic [IDX_W-1:0]  widx, ridx;

    always_comb begin
        wsel = dec_sel(32'(wr_addr));
        widx = dec_idx(32'(wr_addr));
        rsel = dec_sel(32'(rd_addr));
        ridx = dec_idx(32'(rd_addr));
    end

    logic [NL-1:0]          line_en_q;
    logic [NC-1:0]          core_en_q;
    logic [NL-1:0]          swset_q;
    logic [NL-1:0][NC-1:0]  route_q;
    logic [DW-1:0]          rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_en_q <= '0;
            core_en_q <= '0;
            swset_q   <= '0;
            route_q   <= '0;
        end else if (wr_en) begin
            unique case (wsel)
                SEL_LINE_EN: line_en_q    <= wr_data[NL-1:0];
                SEL_CORE_EN: core_en_q    <= wr_data[NC-1:0];
                SEL_SWSET:   swset_q      <= wr_data[NL-1:0];
                SEL_ROUTE:   route_q[widx] <= wr_data[NC-1:0];
                SEL_NONE:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= '0;
            if (rd_en) begin
                unique case (rsel)
                    SEL_LINE_EN: rd_q <= DW'(line_en_q);
                    SEL_CORE_EN: rd_q <= DW'(core_en_q);
                    SEL_SWSET:   rd_q <= DW'(swset_q);
                    SEL_ROUTE:   rd_q <= DW'(route_q[ridx]);
                    SEL_NONE:    rd_q <= '0;
                endcase
            end
        end
    end

    assign rd_data = rd_q;
    assign line_en = line_en_q;
    assign core_en = core_en_q;
    assign swset   = swset_q;
    assign route   = route_q;

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (route_q == '0 && line_en_q == '0 && core_en_q == '0 && swset_q == '0));

    a_r10_unmapped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == SEL_NONE) |=>
            ($stable(route_q) && $stable(line_en_q) && $stable(core_en_q) && $stable(swset_q)));

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || rsel == SEL_NONE) |=> (rd_q == '0));

endmodule

// File: rtl/irqd_fanout.sv
module irqd_fanout #(
    parameter int unsigned NC = 4,
    parameter int unsigned NL = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NL-1:0]          line_act,
    input  logic [NL-1:0]          line_en,
    input  logic [NC-1:0]          core_en,
    input  logic [NL-1:0][NC-1:0]  route,
    output logic [NC*NL-1:0]       core_irq
);

    for (genvar c = 0; c < NC; c++) begin : g_core
        logic [NL-1:0] hit;
        logic [NL-1:0] out_q;

        always_comb begin
            for (int n = 0; n < NL; n++) begin
                hit[n] = line_act[n] & line_en[n] & route[n][c] & core_en[c];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= hit;
        end

        assign core_irq[c*NL +: NL] = out_q;

        a_r5_core_off: assert property (@(posedge clk) disable iff (!rst_n)
            !core_en[c] |=> (out_q == '0));

        a_r4_line_off: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> ((out_q & ~$past(line_en)) == '0));
    end

endmodule

// File: rtl/irqd_distributor.sv
module irqd_distributor #(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_LINES-1:0]           ext_irq,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_data,
    output logic [NUM_CORES*NUM_LINES-1:0] core_irq
);

    logic [NUM_LINES-1:0]                 ext_sync;
    logic [NUM_LINES-1:0]                 line_en;
    logic [NUM_CORES-1:0]                 core_en;
    logic [NUM_LINES-1:0]                 swset;
    logic [NUM_LINES-1:0][NUM_CORES-1:0]  route;
    logic [NUM_LINES-1:0]                 line_act;

    irqd_sync #(.W(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_irq),
        .sync_out (ext_sync)
    );

    irqd_regfile #(
        .NC (NUM_CORES),
        .NL (NUM_LINES),
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .line_en (line_en),
        .core_en (core_en),
        .swset   (swset),
        .route   (route)
    );

    assign line_act = ext_sync | swset;

    irqd_fanout #(
        .NC (NUM_CORES),
        .NL (NUM_LINES)
    ) u_fanout (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_act (line_act),
        .line_en  (line_en),
        .core_en  (core_en),
        .route    (route),
        .core_irq (core_irq)
    );

endmodule

// File: tb/irqd_distributor_tb_top.sv
module irqd_distributor_tb_top;

    localparam int unsigned NC = 4;
    localparam int unsigned NL = 32;
    localparam int unsigned AW = 8;
    localparam int unsigned DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NL-1:0]     ext_irq = '0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [DW-1:0]     wr_data = '0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic [DW-1:0]     rd_data;
    logic [NC*NL-1:0]  core_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irqd_distributor #(
        .NUM_CORES (NC),
        .NUM_LINES (NL),
        .ADDR_W    (AW),
        .DATA_W    (DW)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_irq  (ext_irq),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .core_irq (core_irq)
    );

    // bench model of the programmed state
    logic [NL-1:0] len_m = '0;
    logic [NC-1:0] cen_m = '0;
    logic [NL-1:0] sw_m  = '0;
    logic [NC-1:0] route_m [NL];

    function automatic logic [NC*NL-1:0] exp_out();
        logic [NC*NL-1:0] r;
        r = '0;
        for (int c = 0; c < NC; c++)
            for (int n = 0; n < NL; n++)
                r[c*NL + n] = (ext_irq[n] | sw_m[n]) & route_m[n][c] & len_m[n] & cen_m[c];
        return r;
    endfunction

    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
        int unsigned ai = 32'(a);
        if (a[1:0] != 2'b00) return '0;
        if (ai == 0) return DW'(len_m);
        if (ai == 4) return DW'(cen_m);
        if (ai == 8) return DW'(sw_m);
        if (ai >= 64 && ai < 64 + 4 * NL) return DW'(route_m[(ai - 64) >> 2]);
        return '0;
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int unsigned ai = 32'(a);
        if (a[1:0] != 2'b00) return;
        if (ai == 0)      len_m = d[NL-1:0];
        else if (ai == 4) cen_m = d[NC-1:0];
        else if (ai == 8) sw_m  = d[NL-1:0];
        else if (ai >= 64 && ai < 64 + 4 * NL) route_m[(ai - 64) >> 2] = d[NC-1:0];
    endtask

    task automatic chk_out(input string req, input logic [NC*NL-1:0] exp);
        checks++;
        if (core_irq !== exp) begin
            errors++;
            $display("FAIL %s core_irq actual=%h expected=%h", req, core_irq, exp);
        end
    endtask

    task automatic chk_word(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s rd_data actual=%h expected=%h", req, act, exp);
        end
    endtask

    // returns at the falling edge after the write edge
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    logic [DW-1:0] v;

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < NL; n++) route_m[n] = '0;
        ext_irq = '1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1: reset state
        chk_out("R1 outputs zero after reset", '0);
        chk_word("R1 rd_data idle", rd_data, '0);
        rd(8'h00, v); chk_word("R1 line enable reset", v, '0);
        rd(8'h40, v); chk_word("R1 route line0 reset", v, '0);
        rd(8'hBC, v); chk_word("R1 route last line reset", v, '0);
        wr(8'h00, '1);
        wr(8'h04, '1);
        settle();
        chk_out("R1 no delivery with zero routes", '0);

        // R3: single line, single core, correct pin only
        ext_irq = 32'h0000_0020;
        wr(8'h54, 32'h4);
        settle();
        chk_out("R3 line5 core2 only", 128'(1) << (2*NL + 5));
        chk_out("R2 model match", exp_out());

        // R8: write timing
        wr(8'h54, 32'hF);
        chk_out("R8 no change before edge k+1", 128'(1) << (2*NL + 5));
        @(negedge clk);
        chk_out("R8 change at edge k+1", exp_out());

        // R7: synchroniser latency
        @(negedge clk);
        ext_irq = 32'h0000_0000;
        @(negedge clk); chk_out("R7 edge1 unchanged", (128'(1) << 5) | (128'(1) << 37) | (128'(1) << 69) | (128'(1) << 101));
        @(negedge clk); chk_out("R7 edge2 unchanged", (128'(1) << 5) | (128'(1) << 37) | (128'(1) << 69) | (128'(1) << 101));
        @(negedge clk); chk_out("R7 edge3 cleared", '0);

        // R6: software assert with external low
        wr(8'h08, 32'h0000_0020);
        settle();
        chk_out("R6 soft assert delivers", (128'(1) << 5) | (128'(1) << 37) | (128'(1) << 69) | (128'(1) << 101));

        // R4: line enable gating
        wr(8'h00, 32'hFFFF_FFDF);
        settle();
        chk_out("R4 line disabled", '0);
        wr(8'h00, '1);

        // R5: core enable gating
        wr(8'h04, 32'h5);
        settle();
        chk_out("R5 cores 1,3 disabled", (128'(1) << 5) | (128'(1) << 69));
        wr(8'h04, '1);
        settle();

        // R10: unmapped writes
        wr(8'h0C, '1);
        wr(8'h42, '1);
        wr(8'h01, 32'h0);
        wr(8'hC0, '1);
        settle();
        chk_out("R10 outputs unchanged", exp_out());
        rd(8'h00, v); chk_word("R10 line enable kept", v, exp_rd(8'h00));
        rd(8'h40, v); chk_word("R10 route line0 kept", v, exp_rd(8'h40));
        rd(8'h08, v); chk_word("R10 soft assert kept", v, exp_rd(8'h08));

        // R9: readback and unmapped reads
        rd(8'h54, v); chk_word("R9 route line5", v, 32'hF);
        rd(8'h04, v); chk_word("R9 core enable", v, 32'hF);
        rd(8'h0C, v); chk_word("R9 unmapped 0x0C", v, '0);
        rd(8'h55, v); chk_word("R9 unaligned", v, '0);
        rd(8'hC0, v); chk_word("R9 past last route", v, '0);
        @(negedge clk);
        chk_word("R9 zero when idle", rd_data, '0);

        // R2: random mix
        for (int it = 0; it < 400; it++) begin
            int unsigned kind = $urandom_range(0, 7);
            logic [AW-1:0] a;
            logic [DW-1:0] d = $urandom;
            case (kind)
                0: begin a = 8'h00; d = d | $urandom; end
                1: begin a = 8'h04; d = d | $urandom; end
                2: begin a = 8'h08; d = d & $urandom; end
                7: a = AW'($urandom);
                default: a = AW'(64 + 4 * $urandom_range(0, NL - 1));
            endcase
            wr(a, d);
            ext_irq = $urandom;
            settle();
            chk_out("R2 random gating", exp_out());
            if (it % 8 == 0) begin
                a = AW'($urandom);
                rd(a, v);
                chk_word("R9 random read", v, exp_rd(a));
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule